// File: doc/BRIEF.md
# Task Dependency Synchronizer

This block sits between a source of task ready requests and a task scheduler, and gates every request on the completion state of that task's predecessors. It serves one application of up to `NTASK` tasks. Each task has a static predecessor bitmask, written through a small configuration port. When every predecessor of a requesting task has finished, the block queues a release for it. Otherwise it records the task as blocked.

Every finish event updates a per-task completion vector. Every blocked task is then checked again against the updated vector. Tasks that can now run are woken and queued. Queued releases leave through a valid/ready handshake, one index per accepted transfer, lowest index first.

A task being moved to another compute unit can be withdrawn with a cancel. This drops its blocked record without releasing it. When the moved task asks again, it is released at once if its dependencies were solved in the meantime. A task that has already run is also passed straight on. An application-reset input clears all completion, blocked and queued state, so the next application can start from scratch with the same masks.

Top module: `task_dep_sync`

## Requirements
- R1: After reset, `rel_valid` is low, no task is blocked, no task is complete, and all predecessor masks are zero.
- R2: A request for task r whose predecessors are all complete makes `rel_valid` high with `rel_idx` = r, a binary task index, from the clock edge after the request onward.
- R3: A request for a task with at least one unfinished predecessor produces no release and marks the task blocked.
- R4: A finish event that completes the last missing predecessor of a blocked task makes that task's release visible from the edge after the finish event.
- R5: A finish event and a request in the same cycle are both applied, with the finish applied first. A request whose only missing predecessor finishes in that same cycle is therefore released.
- R6: When several releases are queued, `rel_idx` shows the lowest queued index. `rel_valid` and that index hold while `rel_ready` is low. Each cycle with `rel_valid` and `rel_ready` high removes exactly that index from the queue.
- R7: A cancel for a blocked task drops its blocked record. A later completion of its predecessors does not release it.
- R8: A cancelled task that requests again after its predecessors have completed is released on the edge after its new request.
- R9: With `SELF_BYPASS` set, a request for a task whose own completion bit is set is released even if its predecessors are unfinished.
- R10: `app_clr` empties the completion vector, the blocked set and the release queue. `rel_valid` is low after that edge, and the predecessor masks are kept.
- R11: A write with `cfg_we` stores `cfg_mask` as the predecessor mask of task `cfg_idx`. Bit j set means task j is a predecessor. The new mask governs requests and wakeups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| app_clr | input | 1 | Application reset: clears completion, blocked and queued state |
| cfg_we | input | 1 | Predecessor mask write strobe |
| cfg_idx | input | IDXW | Task whose mask is written |
| cfg_mask | input | NTASK | Predecessor mask, bit j = task j |
| req_valid | input | 1 | Ready request strobe |
| req_idx | input | IDXW | Requesting task |
| fin_valid | input | 1 | Task finished strobe |
| fin_idx | input | IDXW | Finished task |
| cancel_valid | input | 1 | Reallocation cancel strobe |
| cancel_idx | input | IDXW | Task whose blocked record is dropped |
| rel_valid | output | 1 | A release is offered to the scheduler |
| rel_ready | input | 1 | Scheduler accepts the offered release |
| rel_idx | output | IDXW | Index of the offered task |

## Verification
The bench builds the block with its defaults: eight tasks, a three-bit index, and the self-completion bypass enabled. Eight tasks are enough for several simultaneous wakeups, so the ascending release order and the hold under a stalled scheduler can be observed. They also allow dependency chains three levels deep. With the bypass enabled, the bench can also check that a task which has already run is passed straight through.

Directed sequences cover same-cycle finish and request, cancel followed by a late completion, and an application reset with work queued. A seeded random phase then runs masks that point only at lower-indexed tasks, so every chain can complete. It mixes requests, finishes, cancels, rare application resets and a randomly stalled scheduler.

// File: rtl/tds_pkg.sv
package tds_pkg;
   localparam int unsigned TDS_MAX_TASKS = 64;
   localparam int unsigned TDS_MIN_TASKS = 2;

   function automatic int unsigned tds_idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tds_mask_bank.sv
module tds_mask_bank #(
   parameter int unsigned NTASK = 8,
   parameter int unsigned IDXW  = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [IDXW-1:0]        wr_idx,
   input  logic [NTASK-1:0]       wr_mask,
   output logic [NTASK*NTASK-1:0] masks_flat
);
   for (genvar t = 0; t < NTASK; t++) begin : g_row
      logic [NTASK-1:0] row_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            row_q <= '0;
         else if (wr_en && (wr_idx == IDXW'(t)))
            row_q <= wr_mask;
      end
      assign masks_flat[t*NTASK +: NTASK] = row_q;
   end
endmodule

// File: rtl/tds_dep_eval.sv
module tds_dep_eval #(
   parameter int unsigned NTASK = 8
) (
   input  logic [NTASK*NTASK-1:0] masks_flat,
   input  logic [NTASK-1:0]       done_vec,
   output logic [NTASK-1:0]       satisfied
);
   for (genvar t = 0; t < NTASK; t++) begin : g_task
      assign satisfied[t] = ~|(masks_flat[t*NTASK +: NTASK] & ~done_vec);
   end
endmodule

// File: rtl/tds_lowest_pick.sv
module tds_lowest_pick #(
   parameter int unsigned NTASK = 8,
   parameter int unsigned IDXW  = 3
) (
   input  logic [NTASK-1:0] vec,
   output logic             any,
   output logic [IDXW-1:0]  idx,
   output logic [NTASK-1:0] first_oh
);
   logic [NTASK:0] seen;
   assign seen[0] = 1'b0;
   for (genvar i = 0; i < NTASK; i++) begin : g_chain
      assign first_oh[i]  = vec[i] & ~seen[i];
      assign seen[i+1]    = seen[i] | vec[i];
   end
   assign any = seen[NTASK];

   always_comb begin
      idx = '0;
      for (int i = 0; i < NTASK; i++)
         if (first_oh[i]) idx = idx | IDXW'(i);
   end
endmodule

// File: rtl/task_dep_sync.sv
module task_dep_sync
   import tds_pkg::*;
#(
   parameter int unsigned NTASK       = 8,
   parameter bit          SELF_BYPASS = 1'b1,
   localparam int unsigned IDXW       = tds_idx_width(NTASK)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             app_clr,
   input  logic             cfg_we,
   input  logic [IDXW-1:0]  cfg_idx,
   input  logic [NTASK-1:0] cfg_mask,
   input  logic             req_valid,
   input  logic [IDXW-1:0]  req_idx,
   input  logic             fin_valid,
   input  logic [IDXW-1:0]  fin_idx,
   input  logic             cancel_valid,
   input  logic [IDXW-1:0]  cancel_idx,
   output logic             rel_valid,
   input  logic             rel_ready,
   output logic [IDXW-1:0]  rel_idx
);
   if (NTASK < TDS_MIN_TASKS || NTASK > TDS_MAX_TASKS) begin : g_bad_ntask
      $error("task_dep_sync: NTASK out of supported range");
   end

   logic [NTASK-1:0]       done_q, blk_q, pend_q;
   logic [NTASK-1:0]       fin_oh, req_oh, can_oh;
   logic [NTASK-1:0]       done_nx, sat, pass_ok;
   logic [NTASK-1:0]       pick_oh, pop_oh, blk_keep, wake, req_pass, req_hold;
   logic [NTASK-1:0]       blk_d, pend_d;
   logic [NTASK*NTASK-1:0] masks_flat;

   always_comb begin
      for (int i = 0; i < NTASK; i++) begin
         fin_oh[i] = fin_valid    && (fin_idx    == IDXW'(i));
         req_oh[i] = req_valid    && (req_idx    == IDXW'(i));
         can_oh[i] = cancel_valid && (cancel_idx == IDXW'(i));
      end
   end

   tds_mask_bank #(.NTASK(NTASK), .IDXW(IDXW)) u_masks (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_we),
      .wr_idx     (cfg_idx),
      .wr_mask    (cfg_mask),
      .masks_flat (masks_flat)
   );

   // finish events are folded in before any request or wakeup decision
   assign done_nx = done_q | fin_oh;

   tds_dep_eval #(.NTASK(NTASK)) u_eval (
      .masks_flat (masks_flat),
      .done_vec   (done_nx),
      .satisfied  (sat)
   );

   if (SELF_BYPASS) begin : g_bypass
      assign pass_ok = sat | done_nx;
   end else begin : g_strict
      assign pass_ok = sat;
   end

   tds_lowest_pick #(.NTASK(NTASK), .IDXW(IDXW)) u_pick (
      .vec      (pend_q),
      .any      (rel_valid),
      .idx      (rel_idx),
      .first_oh (pick_oh)
   );

   assign pop_oh   = rel_ready ? pick_oh : '0;
   assign blk_keep = blk_q & ~can_oh;
   assign wake     = blk_keep & sat;
   assign req_pass = req_oh & pass_ok;
   assign req_hold = req_oh & ~pass_ok;
   assign blk_d    = (blk_keep & ~wake & ~req_pass) | req_hold;
   assign pend_d   = (pend_q & ~pop_oh) | wake | req_pass;

   always_ff @(posedge clk) begin
      if (!rst_n || app_clr) begin
         done_q <= '0;
         blk_q  <= '0;
         pend_q <= '0;
      end else begin
         done_q <= done_nx;
         blk_q  <= blk_d;
         pend_q <= pend_d;
      end
   end
endmodule

// File: rtl/tds_checker.sv
module tds_checker
   import tds_pkg::*;
#(
   parameter int unsigned NTASK = 8,
   localparam int unsigned IDXW = tds_idx_width(NTASK)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             app_clr,
   input logic             req_valid,
   input logic [IDXW-1:0]  req_idx,
   input logic             cancel_valid,
   input logic [IDXW-1:0]  cancel_idx,
   input logic             rel_valid,
   input logic             rel_ready,
   input logic [IDXW-1:0]  rel_idx,
   input logic [NTASK-1:0] blk_q,
   input logic [NTASK-1:0] pend_q
);
   // R7
   cancel_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_valid && !(req_valid && req_idx == cancel_idx) |=> !blk_q[$past(cancel_idx)]);

   // R10
   clr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      app_clr |=> (!rel_valid && blk_q == '0));

   // R6
   offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid && !rel_ready && !app_clr |=> rel_valid);

   // R6
   accept_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid && rel_ready && !app_clr && !blk_q[rel_idx]
      && !(req_valid && req_idx == rel_idx) |=> !pend_q[$past(rel_idx)]);
endmodule

bind task_dep_sync tds_checker #(.NTASK(NTASK)) u_chk (.*);

// File: tb/task_dep_sync_test.sv
module task_dep_sync_test;
   localparam int N = 8;
   localparam int W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic app_clr = 0, cfg_we = 0, req_valid = 0, fin_valid = 0, cancel_valid = 0, rel_ready = 0;
   logic [W-1:0] cfg_idx = '0, req_idx = '0, fin_idx = '0, cancel_idx = '0;
   logic [N-1:0] cfg_mask = '0;
   logic rel_valid;
   logic [W-1:0] rel_idx;

   int tests = 0, fails = 0;
   logic [N-1:0] m_mask [N];
   logic [N-1:0] m_done, m_blk, m_pend;

   always #10 clk = ~clk;

   task_dep_sync uut (.*);

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic chk_rel(input string rq, input bit ev, input int ei);
      chk(rel_valid == ev, {rq, " valid"}, int'(rel_valid), int'(ev));
      if (ev) chk(int'(rel_idx) == ei, {rq, " index"}, int'(rel_idx), ei);
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic setmask(input int t, input logic [N-1:0] m);
      cfg_we = 1; cfg_idx = W'(t); cfg_mask = m; m_mask[t] = m;
      tick; cfg_we = 0;
   endtask

   task automatic req(input int t);
      req_valid = 1; req_idx = W'(t); tick; req_valid = 0;
   endtask

   task automatic fin(input int t);
      fin_valid = 1; fin_idx = W'(t); tick; fin_valid = 0;
   endtask

   task automatic pop;
      rel_ready = 1; tick; rel_ready = 0;
   endtask

   function automatic int lowest(input logic [N-1:0] v);
      for (int i = N - 1; i >= 0; i--) if (v[i]) lowest = i;
      if (v == '0) lowest = 0;
   endfunction

   function automatic bit satisfied(input int t, input logic [N-1:0] dn);
      return (m_mask[t] & ~dn) == '0;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) m_mask[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk_rel("R1 reset", 0, 0);
      req(0); chk_rel("R1 zero masks after reset release", 1, 0); pop;

      setmask(1, 8'b0000_0001); setmask(2, 8'b0000_0011); setmask(3, 8'b0000_0010);
      setmask(5, 8'b0001_0000); setmask(6, 8'b0001_0000); setmask(7, 8'b0000_0100);
      chk_rel("R2 queue empty after pop", 0, 0);
      req(1); chk_rel("R3 blocked on unfinished predecessor", 0, 0);
      req(0); chk_rel("R2 satisfied request released", 1, 0); pop;
      fin(0); chk_rel("R4 wake on last predecessor", 1, 1); pop;
      req_valid = 1; req_idx = 3; fin_valid = 1; fin_idx = 1; tick;
      req_valid = 0; fin_valid = 0;
      chk_rel("R5 finish applied before request", 1, 3); pop;

      req(6); chk_rel("R3 task 6 blocked", 0, 0);
      req(5); chk_rel("R3 task 5 blocked", 0, 0);
      fin(4); chk_rel("R6 lowest of two wakeups", 1, 5);
      tick;   chk_rel("R6 held while not ready", 1, 5);
      pop;    chk_rel("R6 next index after accept", 1, 6);
      pop;    chk_rel("R6 queue drained", 0, 0);

      req(7); chk_rel("R3 task 7 blocked", 0, 0);
      cancel_valid = 1; cancel_idx = 7; tick; cancel_valid = 0;
      fin(2); chk_rel("R7 cancelled task not woken", 0, 0);
      req(7); chk_rel("R8 re-request after cancel released", 1, 7); pop;

      req(4); chk_rel("R2 task 4 queued", 1, 4);
      app_clr = 1; tick; app_clr = 0;
      chk_rel("R10 queued release dropped", 0, 0);
      req(1); chk_rel("R10 completion forgotten", 0, 0);
      req(0); chk_rel("R10 masks kept", 1, 0); pop;
      app_clr = 1; tick; app_clr = 0;
      fin(0); chk_rel("R10 blocked record dropped", 0, 0);

      fin(3); req(3); chk_rel("R9 completed task bypasses", 1, 3); pop;
      setmask(4, 8'b0000_0010);
      req(4); chk_rel("R11 new mask blocks task 4", 0, 0);
      fin(1); chk_rel("R11 new mask wake", 1, 4); pop;

      // random phase, predecessors only at lower indices
      void'($urandom(32'd1234));
      for (int t = 0; t < N; t++) setmask(t, N'($urandom) & N'((1 << t) - 1));
      app_clr = 1; tick; app_clr = 0;
      m_done = '0; m_blk = '0; m_pend = '0;
      for (int c = 0; c < 4000; c++) begin
         logic [N-1:0] dn, pop_oh, keep, nw;
         int r, f, k;
         bit rv, fv, kv, cl, rd;
         chk(rel_valid == (m_pend != '0), "R6 random valid", int'(rel_valid), int'(m_pend != '0));
         if (m_pend != '0)
            chk(int'(rel_idx) == lowest(m_pend), "R6 random index", int'(rel_idx), lowest(m_pend));
         rv = ($urandom % 10) < 3; r = $urandom % N;
         fv = ($urandom % 10) < 2; f = $urandom % N;
         kv = ($urandom % 10) < 1; k = $urandom % N;
         cl = ($urandom % 200) == 0;
         rd = ($urandom % 10) < 6;
         req_valid = rv; req_idx = W'(r); fin_valid = fv; fin_idx = W'(f);
         cancel_valid = kv; cancel_idx = W'(k); app_clr = cl; rel_ready = rd;
         if (cl) begin
            m_done = '0; m_blk = '0; m_pend = '0;
         end else begin
            dn = m_done; if (fv) dn[f] = 1'b1;
            pop_oh = '0; if (rd && m_pend != '0) pop_oh[lowest(m_pend)] = 1'b1;
            keep = m_blk; if (kv) keep[k] = 1'b0;
            nw = '0;
            for (int i = 0; i < N; i++)
               if (keep[i] && satisfied(i, dn)) begin nw[i] = 1'b1; keep[i] = 1'b0; end
            if (rv) begin
               if (satisfied(r, dn) || dn[r]) begin nw[r] = 1'b1; keep[r] = 1'b0; end
               else keep[r] = 1'b1;
            end
            m_pend = (m_pend & ~pop_oh) | nw;
            m_blk = keep; m_done = dn;
         end
         tick;
      end
      req_valid = 0; fin_valid = 0; cancel_valid = 0; app_clr = 0; rel_ready = 0;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule